// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a control transfer is taken and produces the next instruction pointer. It looks at a 4-bit condition code, a 32-bit flags word, the branch kind, a direct target, a register-supplied target and the fall-through address. A conditional branch goes to the direct target only when its condition holds. Otherwise the pointer moves to the fall-through address. An unconditional direct jump always goes to the direct target. An unconditional register jump always goes to the register value.

The evaluation logic is purely combinational. A parameter `REG_OUT` chooses whether the taken bit and the next pointer leave through an output register (default, one cycle of latency) or straight from the logic. Conditions cover equality, unsigned ordering, signed ordering, overflow and carry. Each condition code comes in a pair, and the low bit of the code inverts the pair's sense.

Top module: `bce_top`

## Requirements
- R1: While rst_ni is low, taken_o is 0 and next_ip_o is 0.
- R2: With REG_OUT=1, both outputs reflect the inputs sampled at the previous rising clock edge, giving one cycle of latency.
- R3: Only four flag bits are read: carry at bit 0, zero at bit 6, sign at bit 7 and overflow at bit 11. Every other bit of flags_i has no effect on the outputs.
- R4: The flag-based codes are: 0 overflow (OF=1), 2 below or carry (CF=1), 4 equal (ZF=1), 6 below-or-equal (CF=1 or ZF=1).
- R5: The signed codes are: 12 less (SF!=OF), 14 less-or-equal (ZF=1 or SF!=OF).
- R6: For every defined pair, the odd code is the negation of the even code below it. This gives 1 no overflow, 3 above-or-equal or no carry, 5 not equal, 7 above, 13 greater-or-equal and 15 greater.
- R7: Codes 8 to 11 are unused and a conditional branch using them is never taken.
- R8: kind_i 0 is conditional. kind_i 1 is direct and always taken to target_i. kind_i 2 is register and always taken to reg_target_i. kind_i 3 is reserved and never taken.
- R9: A taken conditional branch yields next_ip_o = target_i. A not-taken result of any kind yields next_ip_o = fallthru_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| kind_i | input | 2 | Branch kind: 0 conditional, 1 direct, 2 register, 3 reserved |
| cc_i | input | 4 | Condition code |
| flags_i | input | 32 | Flags word |
| target_i | input | 32 | Direct target address |
| reg_target_i | input | 32 | Register-supplied target address |
| fallthru_i | input | 32 | Next sequential instruction address |
| taken_o | output | 1 | Transfer taken |
| next_ip_o | output | 32 | Next instruction pointer |

## Verification
With the default output register, both taken_o and next_ip_o are due exactly one rising edge after the inputs are applied. The bench changes the inputs on a falling edge and compares the outputs on the next falling edge, after the single register stage has loaded. The bench drives every code with directed flag patterns and then applies a seeded random run. It repeats each case with the unused flag bits set, which shows that only the four fixed bit positions matter.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int unsigned CF_POS = 0;
  localparam int unsigned ZF_POS = 6;
  localparam int unsigned SF_POS = 7;
  localparam int unsigned OF_POS = 11;

  typedef enum logic [1:0] {
    KIND_COND = 2'd0,
    KIND_DIR  = 2'd1,
    KIND_REG  = 2'd2,
    KIND_RSV  = 2'd3
  } kind_e;

  // cc[3:1] selects the pair, cc[0] inverts
  typedef enum logic [2:0] {
    PAIR_OVF = 3'd0,
    PAIR_CY  = 3'd1,
    PAIR_EQ  = 3'd2,
    PAIR_BE  = 3'd3,
    PAIR_LT  = 3'd6,
    PAIR_LE  = 3'd7
  } pair_e;
endpackage

// File: rtl/bce_cond_eval.sv
module bce_cond_eval #(
  parameter int unsigned FLAG_W = 32,
  parameter int unsigned CC_W   = 4
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic              cond_o
);
  import bce_pkg::*;

  logic cf, zf, sf, of, lt, base, known;

  assign cf = flags_i[CF_POS];
  assign zf = flags_i[ZF_POS];
  assign sf = flags_i[SF_POS];
  assign of = flags_i[OF_POS];
  assign lt = sf ^ of;

  always_comb begin
    known = 1'b1;
    base  = 1'b0;
    case (cc_i[CC_W-1:1])
      PAIR_OVF: base = of;
      PAIR_CY:  base = cf;
      PAIR_EQ:  base = zf;
      PAIR_BE:  base = cf | zf;
      PAIR_LT:  base = lt;
      PAIR_LE:  base = zf | lt;
      default:  known = 1'b0;
    endcase
  end

  assign cond_o = known & (base ^ cc_i[0]);
endmodule

// File: rtl/bce_target_sel.sv
module bce_target_sel #(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      kind_i,
  input  logic            cond_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] reg_target_i,
  input  logic [XLEN-1:0] fallthru_i,
  output logic            taken_o,
  output logic [XLEN-1:0] next_ip_o
);
  import bce_pkg::*;

  always_comb begin
    taken_o   = 1'b0;
    next_ip_o = fallthru_i;
    case (kind_i)
      KIND_COND: begin
        taken_o = cond_i;
        if (cond_i) next_ip_o = target_i;
      end
      KIND_DIR: begin
        taken_o   = 1'b1;
        next_ip_o = target_i;
      end
      KIND_REG: begin
        taken_o   = 1'b1;
        next_ip_o = reg_target_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bce_top.sv
module bce_top #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned FLAG_W  = 32,
  parameter int unsigned CC_W    = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        kind_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [XLEN-1:0]   target_i,
  input  logic [XLEN-1:0]   reg_target_i,
  input  logic [XLEN-1:0]   fallthru_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_ip_o
);
  logic            cond;
  logic            taken_d;
  logic [XLEN-1:0] nip_d;

  bce_cond_eval #(.FLAG_W(FLAG_W), .CC_W(CC_W)) u_cond (
    .flags_i(flags_i),
    .cc_i   (cc_i),
    .cond_o (cond)
  );

  bce_target_sel #(.XLEN(XLEN)) u_sel (
    .kind_i      (kind_i),
    .cond_i      (cond),
    .target_i    (target_i),
    .reg_target_i(reg_target_i),
    .fallthru_i  (fallthru_i),
    .taken_o     (taken_d),
    .next_ip_o   (nip_d)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic            taken_q;
      logic [XLEN-1:0] nip_q;
      logic            live_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          taken_q <= 1'b0;
          nip_q   <= '0;
          live_q  <= 1'b0;
        end else begin
          taken_q <= taken_d;
          nip_q   <= nip_d;
          live_q  <= 1'b1;
        end
      end

      assign taken_o   = taken_q;
      assign next_ip_o = nip_q;

      // R8
      direct_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == 2'd1) |=> (taken_o && next_ip_o == $past(target_i)));
      // R8
      reg_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == 2'd2) |=> (taken_o && next_ip_o == $past(reg_target_i)));
      // R7
      unused_cc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == 2'd0 && cc_i[CC_W-1:CC_W-2] == 2'b10) |=> !taken_o);
      // R9
      fallthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && !taken_o) |-> next_ip_o == $past(fallthru_i));
      // R8
      reserved_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == 2'd3) |=> !taken_o);
    end else begin : g_comb
      assign taken_o   = taken_d;
      assign next_ip_o = nip_d;
    end
  endgenerate
endmodule

// File: tb/sim_bce_top.sv
`timescale 1ns/1ps
module sim_bce_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [3:0]  cc_i = '0;
  logic [31:0] flags_i = '0;
  logic [31:0] target_i = '0;
  logic [31:0] reg_target_i = '0;
  logic [31:0] fallthru_i = '0;
  logic        taken_o;
  logic [31:0] next_ip_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  bce_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .kind_i(kind_i), .cc_i(cc_i),
    .flags_i(flags_i), .target_i(target_i), .reg_target_i(reg_target_i),
    .fallthru_i(fallthru_i), .taken_o(taken_o), .next_ip_o(next_ip_o)
  );

  // expected condition from the requirement tables
  function automatic bit exp_cond(input logic [3:0] cc, input logic [31:0] f);
    bit c, z, s, o, r;
    c = f[0]; z = f[6]; s = f[7]; o = f[11];
    case (cc)
      4'd0: r = o;         4'd1: r = !o;
      4'd2: r = c;         4'd3: r = !c;
      4'd4: r = z;         4'd5: r = !z;
      4'd6: r = c || z;    4'd7: r = !(c || z);
      4'd12: r = s != o;   4'd13: r = s == o;
      4'd14: r = z || (s != o);
      4'd15: r = !(z || (s != o));
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input bit et, input logic [31:0] ei);
    total++;
    if (taken_o !== et || next_ip_o !== ei) begin
      bad++;
      $display("FAIL %s: taken=%0b next_ip=%h expected taken=%0b next_ip=%h",
               req, taken_o, next_ip_o, et, ei);
    end
  endtask

  // apply on negedge, compare one edge later (R2)
  task automatic run(input string req, input logic [1:0] k, input logic [3:0] cc,
                     input logic [31:0] f);
    bit et;
    logic [31:0] ei;
    kind_i = k; cc_i = cc; flags_i = f;
    target_i = $urandom; reg_target_i = $urandom; fallthru_i = $urandom;
    case (k)
      2'd0: et = exp_cond(cc, f);
      2'd1, 2'd2: et = 1;
      default: et = 0;
    endcase
    ei = !et ? fallthru_i : (k == 2'd2 ? reg_target_i : target_i);
    @(negedge clk_i);
    check(req, et, ei);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    // R1
    check("R1", 0, 32'h0);
    repeat (3) @(negedge clk_i);
    check("R1", 0, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed: every code against all 16 combos of the four flag bits
    for (int cc = 0; cc < 16; cc++) begin
      for (int m = 0; m < 16; m++) begin
        logic [31:0] f;
        f = {20'b0, m[3], 3'b0, m[2], m[1], 5'b0, m[0]};
        if (cc >= 8 && cc <= 11) run("R7", 2'd0, cc[3:0], f);
        else if (cc >= 12) run("R5 R6", 2'd0, cc[3:0], f);
        else run("R4 R6", 2'd0, cc[3:0], f);
        // R3: other bits set must not change the result
        run("R3", 2'd0, cc[3:0], f | 32'hFFFF_F73E);
      end
    end

    // R8 kinds with conflicting conditions
    for (int i = 0; i < 8; i++) begin
      run("R8", 2'd1, 4'd4, 32'h0);
      run("R8", 2'd2, 4'd8, 32'h0);
      run("R8", 2'd3, 4'd5, 32'h0);
    end

    // R9 and R2: back-to-back random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      k = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
      run("R9 R2", k, 4'($urandom), $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: timeout actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule